// File: doc/BRIEF.md
# Time-Slot Bus Slave Serializer

This block is the slave end of a framed serial time-slot bus. The bus master owns the bit clock, a single frame strobe and a per-slot stuff request. The slave drives only the transmit data line. Each frame is a fixed number of eight-bit slots, sent most significant bit first. Transmit and receive share the strobe and the clock, so their slots line up.

On the parallel side, the block asks for the next transmit byte one slot in advance. It does this with a one-cycle request that carries that byte's slot index. It also reports each received byte with a one-cycle valid pulse and the byte's slot index. Transmit bits change on the rising clock edge, and receive bits are captured on the falling edge.

The master can ask for a slot to be stuffed. The block then sends an all-ones filler eight slots after the slot in which the request was taken, counting across frame boundaries. After the first strobe, the slot counter keeps running on its own when a strobe is missing, and any strobe forces it back to slot 0.

Top module: `tsb_slave`

## Requirements
- R1: From reset until the first rising edge that samples `strobe` high, `tdat` is 1, `rx_valid` is 0 and `tx_req` is 0, whatever `rdat`, `stuff_req` and `tx_byte` do.
- R2: A rising edge with `strobe` high starts slot 0 at once. In the clock cycle after that edge, `tdat` carries bit 7 of the `tx_byte` sampled at that edge.
- R3: Each slot is 8 clock cycles long. `tdat` presents bits 7 down to 0 of the loaded byte, one bit per cycle, and changes only at rising edges.
- R4: In the first bit cycle of every slot, `tx_req` is high for one cycle and `tx_req_slot` gives the index of the following slot, (current + 1) mod SLOTS. `tx_byte` is sampled only at the rising edge that starts that slot, and changes to it in any other cycle have no effect on `tdat`.
- R5: `rdat` is sampled on the falling edge in the middle of each bit cycle. The first sample of a slot becomes bit 7 of the received byte and the eighth sample becomes bit 0.
- R6: In the first bit cycle of the next slot, `rx_valid` is high for exactly one cycle, with `rx_data` holding the completed byte and `rx_slot` holding that byte's slot index.
- R7: If no strobe arrives, the slot after slot SLOTS-1 is slot 0. This wrap shows in both `tx_req_slot` and `rx_slot`.
- R8: A strobe in the middle of a slot abandons that slot. No `rx_valid` pulse is given for the partial byte, and slot 0 starts at the strobe edge as in R2.
- R9: If `stuff_req` is high at the rising edge that starts slot n, then slot n+8 (counting slots across frames) sends eight ones on `tdat`, whatever `tx_byte` is.
- R10: `stuff_req` is sampled only at slot-start edges. A value that is high only in the other cycles of a slot does not stuff any later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock from the master |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe | input | 1 | Frame strobe, high for one cycle at the start of slot 0 |
| stuff_req | input | 1 | Stuff request, sampled at slot-start edges |
| rdat | input | 1 | Serial receive data |
| tdat | output | 1 | Serial transmit data |
| tx_byte | input | 8 | Transmit byte for the slot named by `tx_req_slot` |
| tx_req | output | 1 | Request pulse for the next transmit byte |
| tx_req_slot | output | $clog2(SLOTS) | Slot index of the requested byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse qualifying `rx_data` and `rx_slot` |
| rx_slot | output | $clog2(SLOTS) | Slot index of the received byte |

## Verification
The bench walks a table of per-slot transmit bytes, receive bytes and stuff flags through aligned frames. It then repeats the walk with the strobe left out, which separates strobe-driven slot counting from the free-running wrap. During each slot, `tx_byte` is driven inverted outside the slot-start edge and stuff is raised only inside a slot, so sampling at the wrong edge shows up as wrong bits. Stuff requests late in a frame check that the eight-slot delay is counted in slots rather than frames, and a strobe three bits into a slot checks that the partial byte is dropped and slot 0 restarts.

// File: rtl/tsb_slave.sv
module tsb_slave #(
  parameter int SLOTS = 32,
  parameter int STUFF_LAG = 8,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          stuff_req,
  input  logic          rdat,
  output logic          tdat,
  input  logic [7:0]    tx_byte,
  output logic          tx_req,
  output logic [SW-1:0] tx_req_slot,
  output logic [7:0]    rx_data,
  output logic          rx_valid,
  output logic [SW-1:0] rx_slot
);

  logic                 synced;
  logic [2:0]           bit_cnt;
  logic [SW-1:0]        slot, slot_nx;
  logic [7:0]           tx_sh, rx_sh;
  logic [STUFF_LAG-1:0] fill_q;
  logic                 last_bit, boundary;

  assign last_bit = synced && (bit_cnt == 3'd0);
  assign boundary = strobe || last_bit;
  assign slot_nx  = (slot == SW'(SLOTS - 1)) ? '0 : slot + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced   <= 1'b0;
      bit_cnt  <= 3'd0;
      slot     <= '0;
      tx_sh    <= 8'hFF;
      fill_q   <= '0;
      rx_valid <= 1'b0;
      rx_data  <= 8'h00;
      rx_slot  <= '0;
    end else begin
      rx_valid <= last_bit;
      if (last_bit) begin
        rx_data <= rx_sh;
        rx_slot <= slot;
      end
      if (boundary) begin
        synced  <= 1'b1;
        bit_cnt <= 3'd7;
        slot    <= strobe ? '0 : slot_nx;
        tx_sh   <= fill_q[STUFF_LAG-1] ? 8'hFF : tx_byte;
        fill_q  <= {fill_q[STUFF_LAG-2:0], stuff_req};
      end else if (synced) begin
        bit_cnt <= bit_cnt - 3'd1;
        tx_sh   <= {tx_sh[6:0], 1'b1};
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_sh <= 8'h00;
    else if (synced) rx_sh <= {rx_sh[6:0], rdat};
  end

  assign tdat        = synced ? tx_sh[7] : 1'b1;
  assign tx_req      = synced && (bit_cnt == 3'd7);
  assign tx_req_slot = slot_nx;

  logic [SW:0] ahead_sum, ahead_exp;
  assign ahead_sum = (SW+1)'(rx_slot) + (SW+1)'(2);
  assign ahead_exp = (ahead_sum >= (SW+1)'(SLOTS)) ? ahead_sum - (SW+1)'(SLOTS) : ahead_sum;

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (tdat && !rx_valid && !tx_req));

  assert_strobe_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (tx_req && tx_req_slot == SW'(1 % SLOTS)));

  assert_req_ahead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && rx_valid && !$past(strobe)) |-> ({1'b0, tx_req_slot} == ahead_exp));

  assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_rx_with_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> tx_req);

endmodule

// File: tb/tsb_slave_tb.sv
module tsb_slave_tb;
  localparam int N = 32;
  localparam int SW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, stuff_req = 1'b0, rdat = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic tdat, tx_req, rx_valid;
  logic [SW-1:0] tx_req_slot, rx_slot;
  logic [7:0] rx_data;

  always #4 clk = ~clk;

  tsb_slave #(.SLOTS(N), .STUFF_LAG(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .stuff_req(stuff_req),
    .rdat(rdat), .tdat(tdat), .tx_byte(tx_byte), .tx_req(tx_req),
    .tx_req_slot(tx_req_slot), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_slot(rx_slot)
  );

  // {tx byte, rx byte, stuff}
  localparam logic [16:0] VEC [16] = '{
    {8'hA5, 8'h3C, 1'b0}, {8'h01, 8'h80, 1'b0}, {8'h80, 8'h01, 1'b0}, {8'h5A, 8'hC3, 1'b1},
    {8'hFF, 8'h00, 1'b0}, {8'h00, 8'hFF, 1'b0}, {8'h96, 8'h69, 1'b0}, {8'h7E, 8'h81, 1'b0},
    {8'h12, 8'h34, 1'b0}, {8'hC0, 8'h0C, 1'b0}, {8'h33, 8'hCC, 1'b0}, {8'h00, 8'h55, 1'b0},
    {8'h0F, 8'hF0, 1'b0}, {8'h6D, 8'hB6, 1'b1}, {8'h24, 8'h42, 1'b0}, {8'hE7, 8'h18, 1'b0}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int cur = 0, prev_slot = 0;
  bit prev_full = 1'b0, prev_partial = 1'b0, prev_wrapped = 1'b0;
  logic [7:0] prev_rx = 8'h00, hist = 8'h00, hmid = 8'h00;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_slot(input bit stb, input logic [7:0] txb, input logic [7:0] rxb,
                          input bit stf, input bit mid_stf, input int nbits);
    bit fill, fmid, wrapped;
    string tg;
    fill = 1'b0; fmid = 1'b0; wrapped = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      strobe    = (k == 0) && stb;
      stuff_req = (k == 0) ? stf : mid_stf;
      tx_byte   = (k == 0) ? txb : ~txb;
      if (k == 0) begin
        fill = hist[7];
        fmid = hmid[7];
        hist = {hist[6:0], stf};
        hmid = {hmid[6:0], mid_stf && !stf};
        wrapped = !stb && (cur == N - 1);
        cur = stb ? 0 : (cur + 1) % N;
      end
      @(posedge clk);
      #1 rdat = rxb[7-k];
      @(negedge clk);
      if (fill) tg = "R9";
      else if (fmid) tg = "R10";
      else if (k == 0 && stb) tg = "R2";
      else tg = "R3";
      chk(tg, "tdat", {7'd0, tdat}, {7'd0, fill ? 1'b1 : txb[7-k]});
      chk("R4", "tx_req", {7'd0, tx_req}, {7'd0, k == 0});
      if (k == 0) begin
        chk(wrapped || cur == N - 1 ? "R7" : "R4", "tx_req_slot", 8'(tx_req_slot), 8'((cur + 1) % N));
        chk(prev_partial ? "R8" : "R6", "rx_valid", {7'd0, rx_valid}, {7'd0, prev_full});
        if (prev_full) begin
          chk("R5", "rx_data", rx_data, prev_rx);
          chk(prev_wrapped ? "R7" : "R6", "rx_slot", 8'(rx_slot), 8'(prev_slot));
        end
      end else begin
        chk("R6", "rx_valid", {7'd0, rx_valid}, 8'd0);
      end
    end
    prev_full    = (nbits == 8);
    prev_partial = (nbits < 8);
    prev_rx      = rxb;
    prev_slot    = cur;
    prev_wrapped = wrapped;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [16:0] v;
    repeat (3) @(negedge clk);
    chk("R1", "tdat in reset", {7'd0, tdat}, 8'd1);
    chk("R1", "rx_valid in reset", {7'd0, rx_valid}, 8'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      stuff_req = 1'b1;
      tx_byte   = 8'h00;
      rdat      = i[0];
      @(negedge clk);
      chk("R1", "tdat pre-sync", {7'd0, tdat}, 8'd1);
      chk("R1", "rx_valid pre-sync", {7'd0, rx_valid}, 8'd0);
      chk("R1", "tx_req pre-sync", {7'd0, tx_req}, 8'd0);
    end
    stuff_req = 1'b0;

    for (int f = 0; f < 2; f++)
      for (int s = 0; s < N; s++) begin
        v = VEC[s % 16];
        run_slot(s == 0, v[16:9], v[8:1], v[0], 1'b0, 8);
      end

    for (int s = 0; s < N; s++) begin
      v = VEC[(s + 5) % 16];
      run_slot(1'b0, v[16:9], v[8:1], v[0], 1'b0, 8);
    end

    for (int s = 0; s < 3; s++) run_slot(1'b0, 8'h00, 8'h5A, 1'b0, 1'b1, 8);
    for (int s = 0; s < 9; s++) run_slot(1'b0, 8'h00, 8'hA5, 1'b0, 1'b0, 8);

    run_slot(1'b0, 8'h3C, 8'hFF, 1'b0, 1'b0, 3);
    run_slot(1'b1, 8'hC9, 8'h27, 1'b0, 1'b0, 8);
    for (int s = 0; s < 10; s++) begin
      v = VEC[s];
      run_slot(1'b0, v[16:9], v[8:1], 1'b0, 1'b0, 8);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule